// File: doc/BRIEF.md
# Vertical Sync Countdown Generator

This block produces field timing for a 525-line, 60 Hz display. It runs on a fast reference clock `clk`. A one-cycle `line_tick` strobe marks each horizontal line, and the sliced, active-low composite sync arrives on `csync_n`. A low run on `csync_n` that lasts long enough counts as a vertical sync. The block measures the period of each such sync in lines. It locks its field line counter only to syncs whose period falls inside an allowed window, which corresponds to roughly 55 to 67 Hz.

While the block is unlocked, or while free-run is forced, the field counter wraps on its own period of 262 lines. Two registered outputs are decoded from the field counter. `vdrive` is the vertical drive pulse and `vblank` is the vertical blanking pulse. Both start at a programmable line offset from the start of the field. `vsync_missing` reads 1 whenever the block is not locked.

Register inputs control the block. They select the width threshold for sync qualification, the number of consecutive windows needed to lock, and the start offset (a 3-bit field in steps of two lines). They can also force free-run, stop the drive output and disable blanking.

Top module: `vsync_countdown`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `vdrive` = 0, `vblank` = 0 and `vsync_missing` = 1.
- R2: A vertical sync is recognised when `csync_n` is sampled low on at least QUAL_LONG consecutive `clk` edges (`qual_short` = 0) or at least QUAL_SHORT consecutive edges (`qual_short` = 1). Shorter low runs are ignored.
- R3: The period P of a sync is the number of `line_tick` strobes from the end of the line holding the previous reference sync to the end of the line holding this sync. The sync is accepted only when WIN_MIN <= P <= WIN_MAX. While the block is locked, a sync outside the window does not move the field timing.
- R4: With `one_window` = 1, the first accepted sync locks the block. With `one_window` = 0, two consecutive accepted syncs are needed. While unlocked, a sync outside the window becomes the new reference and clears the count of accepted syncs.
- R5: A sync that is accepted while locked, or that completes the lock, restarts the field. The field line counter is 0 after the `line_tick` that ends the sync's line.
- R6: After the last accepted sync, the first expected window ends WIN_MAX lines later and each further one ends FREE_LINES lines after that. If two windows pass in a row with no accepted sync, the block unlocks and `vsync_missing` returns to 1. A single missed window keeps the lock.
- R7: While unlocked, the field counter wraps every FREE_LINES lines, so `vdrive` rises every FREE_LINES line periods.
- R8: `free_force` = 1 unlocks the block from the next cycle and ignores all syncs. The field counter then runs freely at FREE_LINES lines per field.
- R9: `vdrive` is high for DRIVE_LINES lines. It starts `vshift` * SHIFT_STEP lines after the field start, with one `clk` of register delay after the line counter changes.
- R10: `vblank` is high for BLANK_LINES lines, starting on the same line as `vdrive`. While `blank_off` = 1 it stays low.
- R11: While `vout_stop` = 1, `vdrive` stays low, and `vblank` is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle strobe per horizontal line |
| csync_n | input | 1 | Sliced composite sync, active low |
| qual_short | input | 1 | 1 selects the short sync width threshold |
| one_window | input | 1 | 1: one accepted sync locks; 0: two consecutive needed |
| vshift | input | 3 | Start offset in steps of SHIFT_STEP lines |
| free_force | input | 1 | Force free-run, ignore sync |
| vout_stop | input | 1 | Hold the drive output low |
| blank_off | input | 1 | Hold the blanking output low |
| vdrive | output | 1 | Vertical drive pulse |
| vblank | output | 1 | Vertical blanking pulse |
| vsync_missing | output | 1 | 1 while not locked to vertical sync |

## Verification
The bench sweeps the sync period from below the lower window edge to above the upper one. A window compare that is off by one line would flip the lock result at exactly 34 or 46 lines. Sync widths equal to each threshold and one clock short of it are tried; an off-by-one qualifier would lock on the short pulse or miss the exact one. Two-window mode is tested with a streak broken by an out-of-window sync, which catches a design that counts accepted syncs that are not consecutive. The loss test checks that the lock survives one missed window and drops after the second. A design that unlocks too early or never unlocks fails one of those two samples. The offset sweep checks the drive and blank rise times against the sync for all eight `vshift` values.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    localparam int SHIFT_W = 3;

    typedef enum logic {
        WIN_PAIR   = 1'b0,
        WIN_SINGLE = 1'b1
    } win_mode_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic               stop;
        logic               blank_off;
    } out_ctl_t;

    typedef struct packed {
        logic accept;
        logic anchor;
        logic miss;
    } lock_evt_t;

    function automatic logic in_span(input int unsigned pos,
                                     input int unsigned first,
                                     input int unsigned len);
        return (pos >= first) && (pos < first + len);
    endfunction

    function automatic logic [1:0] streak_inc(input logic [1:0] s);
        return (s == 2'd2) ? 2'd2 : s + 2'd1;
    endfunction

endpackage

// File: rtl/vsc_sync_qual.sv
module vsc_sync_qual #(
    parameter int QUAL_LONG  = 486,
    parameter int QUAL_SHORT = 378
) (
    input  logic clk,
    input  logic rst,
    input  logic csync_n,
    input  logic qual_short,
    input  logic line_tick,
    input  logic ignore,
    output logic sync_line
);
    localparam int QW = $clog2(QUAL_LONG + 1);
    localparam logic [QW-1:0] THR_L = QW'(QUAL_LONG);
    localparam logic [QW-1:0] THR_S = QW'(QUAL_SHORT);

    logic [QW-1:0] low_run;
    logic [QW-1:0] thr;
    logic          hit;
    logic          pend;

    always_comb begin
        thr = qual_short ? THR_S : THR_L;
        hit = !csync_n && (low_run == thr - QW'(1));
    end

    // length of the current low run, saturating
    always_ff @(posedge clk) begin
        if (rst || csync_n)
            low_run <= '0;
        else if (low_run != '1)
            low_run <= low_run + QW'(1);
    end

    // a qualified sync is held until the line it fell in ends
    always_ff @(posedge clk) begin
        if (rst || line_tick)
            pend <= 1'b0;
        else if (hit)
            pend <= 1'b1;
    end

    assign sync_line = line_tick && (pend || hit) && !ignore;

    assert_pend_clears_R2: assert property (@(posedge clk) disable iff (rst)
        line_tick |=> !pend);
    assert_pend_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> !$past(csync_n));

endmodule

// File: rtl/vsc_lock_ctrl.sv
module vsc_lock_ctrl
    import vsc_pkg::*;
#(
    parameter int FREE_LINES = 262,
    parameter int WIN_MIN    = 235,
    parameter int WIN_MAX    = 286
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_tick,
    input  logic      sync_line,
    input  logic      force_free,
    input  win_mode_e mode,
    output logic      locked,
    output logic      restart
);
    localparam int PW = $clog2(WIN_MAX + 1);
    localparam logic [PW-1:0] REWIND = PW'(WIN_MAX - FREE_LINES);

    logic [PW-1:0] pcnt;
    logic [1:0]    streak;
    logic [1:0]    streak_nx;
    logic          missed;
    logic          in_win;
    logic          gains;
    int            period;
    int            need;
    lock_evt_t     ev;

    always_comb begin
        period     = int'(pcnt) + 1;
        in_win     = (period >= WIN_MIN) && (period <= WIN_MAX);
        need       = (mode == WIN_SINGLE) ? 1 : 2;
        streak_nx  = streak_inc(streak);
        ev.accept  = sync_line && in_win;
        ev.anchor  = sync_line && !in_win && !locked;
        ev.miss    = line_tick && !ev.accept && !ev.anchor && (period == WIN_MAX);
        gains      = ev.accept && (int'(streak_nx) >= need);
        restart    = ev.accept && (locked || gains);
    end

    always_ff @(posedge clk) begin
        if (rst || force_free) begin
            pcnt   <= '0;
            streak <= '0;
            missed <= 1'b0;
            locked <= 1'b0;
        end else if (line_tick) begin
            if (ev.accept) begin
                pcnt   <= '0;
                streak <= streak_nx;
                missed <= 1'b0;
                if (gains)
                    locked <= 1'b1;
            end else if (ev.anchor) begin
                pcnt   <= '0;
                streak <= '0;
            end else if (ev.miss) begin
                pcnt   <= REWIND;
                streak <= '0;
                missed <= locked && !missed;
                if (missed)
                    locked <= 1'b0;
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end
    end

    assert_period_cap_R6: assert property (@(posedge clk) disable iff (rst)
        int'(pcnt) < WIN_MAX);
    assert_lock_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(sync_line));
    assert_force_unlock_R8: assert property (@(posedge clk) disable iff (rst)
        force_free |=> !locked);

endmodule

// File: rtl/vsc_field_ctr.sv
module vsc_field_ctr #(
    parameter int FREE_LINES = 262,
    parameter int LW         = $clog2(FREE_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_tick,
    input  logic          restart,
    output logic [LW-1:0] line_idx
);
    localparam logic [LW-1:0] LAST = LW'(FREE_LINES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            line_idx <= '0;
        else if (line_tick) begin
            if (restart || line_idx == LAST)
                line_idx <= '0;
            else
                line_idx <= line_idx + LW'(1);
        end
    end

    assert_line_range_R7: assert property (@(posedge clk) disable iff (rst)
        int'(line_idx) < FREE_LINES);
    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
        restart |=> line_idx == '0);

endmodule

// File: rtl/vsc_pulse_gen.sv
module vsc_pulse_gen
    import vsc_pkg::*;
#(
    parameter int LW          = 9,
    parameter int DRIVE_LINES = 8,
    parameter int BLANK_LINES = 24,
    parameter int SHIFT_STEP  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] line_idx,
    input  out_ctl_t      ctl,
    output logic          vdrive,
    output logic          vblank
);
    int unsigned start;
    int unsigned pos;

    always_comb begin
        start = 32'(ctl.shift) * 32'(SHIFT_STEP);
        pos   = 32'(line_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vdrive <= 1'b0;
            vblank <= 1'b0;
        end else begin
            vdrive <= !ctl.stop && in_span(pos, start, 32'(DRIVE_LINES));
            vblank <= !ctl.blank_off && in_span(pos, start, 32'(BLANK_LINES));
        end
    end

    assert_stop_low_R11: assert property (@(posedge clk) disable iff (rst)
        ctl.stop |=> !vdrive);
    assert_blank_off_low_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.blank_off |=> !vblank);

endmodule

// File: rtl/vsync_countdown.sv
module vsync_countdown
    import vsc_pkg::*;
#(
    parameter int FREE_LINES  = 262,
    parameter int WIN_MIN     = 235,
    parameter int WIN_MAX     = 286,
    parameter int DRIVE_LINES = 8,
    parameter int BLANK_LINES = 24,
    parameter int SHIFT_STEP  = 2,
    parameter int QUAL_LONG   = 486,
    parameter int QUAL_SHORT  = 378
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_tick,
    input  logic       csync_n,
    input  logic       qual_short,
    input  logic       one_window,
    input  logic [2:0] vshift,
    input  logic       free_force,
    input  logic       vout_stop,
    input  logic       blank_off,
    output logic       vdrive,
    output logic       vblank,
    output logic       vsync_missing
);
    localparam int LW = $clog2(FREE_LINES);

    logic          sync_line;
    logic          locked;
    logic          restart;
    logic [LW-1:0] line_idx;
    win_mode_e     mode;
    out_ctl_t      ctl;

    assign mode = one_window ? WIN_SINGLE : WIN_PAIR;
    assign ctl  = '{shift: vshift, stop: vout_stop, blank_off: blank_off};

    vsc_sync_qual #(
        .QUAL_LONG (QUAL_LONG),
        .QUAL_SHORT(QUAL_SHORT)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .csync_n   (csync_n),
        .qual_short(qual_short),
        .line_tick (line_tick),
        .ignore    (free_force),
        .sync_line (sync_line)
    );

    vsc_lock_ctrl #(
        .FREE_LINES(FREE_LINES),
        .WIN_MIN   (WIN_MIN),
        .WIN_MAX   (WIN_MAX)
    ) u_lock (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .sync_line (sync_line),
        .force_free(free_force),
        .mode      (mode),
        .locked    (locked),
        .restart   (restart)
    );

    vsc_field_ctr #(
        .FREE_LINES(FREE_LINES),
        .LW        (LW)
    ) u_field (
        .clk      (clk),
        .rst      (rst),
        .line_tick(line_tick),
        .restart  (restart),
        .line_idx (line_idx)
    );

    vsc_pulse_gen #(
        .LW         (LW),
        .DRIVE_LINES(DRIVE_LINES),
        .BLANK_LINES(BLANK_LINES),
        .SHIFT_STEP (SHIFT_STEP)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .line_idx(line_idx),
        .ctl     (ctl),
        .vdrive  (vdrive),
        .vblank  (vblank)
    );

    assign vsync_missing = !locked;

    assert_reset_flag_R1: assert property (@(posedge clk)
        rst |=> vsync_missing && !vdrive && !vblank);

endmodule

// File: tb/vsync_countdown_test.sv
module vsync_countdown_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINE  = 8;
    localparam int FREE  = 40;
    localparam int WMIN  = 34;
    localparam int WMAX  = 46;
    localparam int DRV   = 3;
    localparam int BLK   = 6;
    localparam int STEP  = 2;
    localparam int QL    = 6;
    localparam int QS    = 4;

    logic clk = 1'b0, rst = 1'b1, line_tick = 1'b0, csync_n = 1'b1;
    logic qual_short = 1'b0, one_window = 1'b1, free_force = 1'b0;
    logic vout_stop = 1'b0, blank_off = 1'b0;
    logic [2:0] vshift = 3'd0;
    logic vdrive, vblank, vsync_missing;

    int checks = 0, errors = 0, ncnt = 0;
    int rise_d = -1, rise_prev = -1, rise_b = -1, hi_d = 0, hi_b = 0, sync_at = 0, s0 = 0;
    logic prev_d = 1'b0, prev_b = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsync_countdown #(
        .FREE_LINES(FREE), .WIN_MIN(WMIN), .WIN_MAX(WMAX),
        .DRIVE_LINES(DRV), .BLANK_LINES(BLK), .SHIFT_STEP(STEP),
        .QUAL_LONG(QL), .QUAL_SHORT(QS)
    ) uut (
        .clk(clk), .rst(rst), .line_tick(line_tick), .csync_n(csync_n),
        .qual_short(qual_short), .one_window(one_window), .vshift(vshift),
        .free_force(free_force), .vout_stop(vout_stop), .blank_off(blank_off),
        .vdrive(vdrive), .vblank(vblank), .vsync_missing(vsync_missing)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit tick, input bit low);
        @(negedge clk);
        ncnt++;
        if (vdrive && !prev_d) begin rise_prev = rise_d; rise_d = ncnt; end
        if (vblank && !prev_b) rise_b = ncnt;
        if (vdrive) hi_d++;
        if (vblank) hi_b++;
        prev_d = vdrive;
        prev_b = vblank;
        line_tick = tick;
        csync_n = !low;
    endtask

    task automatic line(input int w);
        for (int ph = 0; ph < LINE; ph++) step(ph == 0, ph >= 1 && ph <= w);
    endtask

    task automatic force_line();
        free_force = 1'b1;
        line(0);
        free_force = 1'b0;
    endtask

    // anchor sync, then a second sync p lines later, then one line to process it
    task automatic try_pair(input int p, input int w);
        force_line();
        line(w);
        repeat (p - 1) line(0);
        line(w);
        line(0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) step(1'b1, 1'b0);
        check("R1 vdrive", int'(vdrive), 0);
        check("R1 vblank", int'(vblank), 0);
        check("R1 missing", int'(vsync_missing), 1);
        rst = 1'b0;
        step(1'b0, 1'b0);
        check("R1 missing after release", int'(vsync_missing), 1);

        // R7 R9 R10 free-run period and pulse widths
        repeat (45) line(0);
        hi_d = 0; hi_b = 0;
        repeat (FREE) line(0);
        check("R9 drive width", hi_d, DRV * LINE);
        check("R10 blank width", hi_b, BLK * LINE);
        check("R7 free period", rise_d - rise_prev, FREE * LINE);
        check("R7 unlocked", int'(vsync_missing), 1);

        // R2 qualifier thresholds
        qual_short = 1'b0;
        try_pair(37, QL - 1);
        check("R2 long rejects short run", int'(vsync_missing), 1);
        try_pair(37, QL);
        check("R2 long accepts exact run", int'(vsync_missing), 0);
        qual_short = 1'b1;
        try_pair(37, QS - 1);
        check("R2 short rejects short run", int'(vsync_missing), 1);
        try_pair(37, QS);
        check("R2 short accepts exact run", int'(vsync_missing), 0);

        // R3 window sweep across both edges
        for (int p = 30; p <= 50; p++) begin
            try_pair(p, 5);
            check($sformatf("R3 period %0d", p), int'(vsync_missing),
                  (p >= WMIN && p <= WMAX) ? 0 : 1);
        end

        // R4 two-window mode
        one_window = 1'b0;
        force_line();
        line(5); repeat (36) line(0); line(5); line(0);
        check("R4 pair not locked after one", int'(vsync_missing), 1);
        repeat (35) line(0); line(5); line(0);
        check("R4 pair locked after two", int'(vsync_missing), 0);
        force_line();
        line(5); repeat (36) line(0); line(5);
        repeat (19) line(0); line(5);
        repeat (36) line(0); line(5); line(0);
        check("R4 broken streak", int'(vsync_missing), 1);
        one_window = 1'b1;

        // R5 R9 R10 offset sweep while locked
        try_pair(37, 5);
        repeat (35) line(0);
        for (int s = 0; s < 8; s++) begin
            vshift = 3'(s);
            sync_at = ncnt + 2;
            line(5);
            repeat (36) line(0);
            check($sformatf("R9 drive start shift %0d", s), rise_d - sync_at,
                  LINE + 1 + s * STEP * LINE);
            check($sformatf("R10 blank start shift %0d", s), rise_b - sync_at,
                  LINE + 1 + s * STEP * LINE);
        end
        vshift = 3'd0;

        // R3 out-of-window sync ignored while locked, R5 restart
        sync_at = ncnt + 2;
        s0 = sync_at;
        line(5);
        repeat (19) line(0);
        line(5);
        repeat (16) line(0);
        check("R3 out-of-window no restart", rise_d - s0, LINE + 1);
        check("R3 lock kept", int'(vsync_missing), 0);
        sync_at = ncnt + 2;
        line(5);
        repeat (36) line(0);
        check("R5 restart on accepted", rise_d - sync_at, LINE + 1);

        // R6 loss after two missed windows
        repeat (24) line(0);
        check("R6 one miss keeps lock", int'(vsync_missing), 0);
        repeat (30) line(0);
        check("R6 two misses unlock", int'(vsync_missing), 1);

        // R8 forced free-run ignores sync
        try_pair(37, 5);
        check("R8 locked before force", int'(vsync_missing), 0);
        free_force = 1'b1;
        for (int k = 0; k < 4; k++) begin
            repeat (36) line(0);
            line(5);
        end
        check("R8 forced unlocked", int'(vsync_missing), 1);
        check("R8 forced period", rise_d - rise_prev, FREE * LINE);
        free_force = 1'b0;

        // R11 stop, R10 blank off
        vout_stop = 1'b1;
        line(0);
        hi_d = 0; hi_b = 0;
        repeat (FREE) line(0);
        check("R11 drive held low", hi_d, 0);
        check("R11 blank unaffected", hi_b, BLK * LINE);
        vout_stop = 1'b0;
        blank_off = 1'b1;
        line(0);
        hi_d = 0; hi_b = 0;
        repeat (FREE) line(0);
        check("R10 blank held low", hi_b, 0);
        check("R10 drive unaffected", hi_d, DRV * LINE);
        blank_off = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule